// File: doc/BRIEF.md
# Instruction Block Slot Sequencer

This block sits between an instruction fetch path and a decoder. It takes one 256-bit instruction block at a time and hands its 32-bit slots to the decoder one at a time, in ascending slot order, over a valid/ready handshake. A block may begin with a header of 32, 48 or 64 bits. The fetch side flags whether a header is present and gives its length in 16-bit units. The header also carries a 3-bit count of trailing slots that hold data, not instructions. The sequencer skips the header slots and stops before the trailing data slots.

A taken branch may land in the middle of a block. The fetch side still delivers the whole block, together with the 3-bit index of the target slot. Issue then begins at whichever is later: the target slot or the first slot after the header. When the decoder accepts the last instruction slot, the sequencer pulses a done flag and raises its block-ready output again. That ready output is the request for the next block. A block whose data area would cover the header or the branch target issues nothing and raises an error pulse instead.

Top module: `blk_slot_seq`

## Requirements
- R1: After reset, blk_ready is 1, and slot_valid, blk_done and blk_err are 0.
- R2: When blk_hdr is 0, slots 0 to 7 are issued in ascending order, each exactly once. Slot k carries blk_data bits [32k+31:32k] and slot_idx equals k. blk_hdr_len and blk_rsv have no effect.
- R3: When blk_hdr is 1, the header covers the first ceil(L/2) slots, where L is blk_hdr_len in 16-bit units. So L=2 starts issue at slot 1, and L=3 or L=4 start issue at slot 2.
- R4: When blk_hdr is 1, the last slot issued is 7 minus blk_rsv, and no slot above it is issued.
- R5: The first slot issued is the larger of blk_target and the first slot after the header. Slots below it are not issued.
- R6: If that first slot is above the last slot, the block issues no slot. blk_err is then 1 for exactly the one cycle after acceptance, blk_done stays 0, and blk_ready is 1 again in that same cycle.
- R7: blk_done is 1 for exactly one cycle: the cycle after the last slot is accepted. blk_ready is 1 in that same cycle, which requests the next sequential block.
- R8: While slot_valid is 1 and slot_ready is 0, slot_valid, slot_idx and slot_data hold their values into the next cycle.
- R9: While slots are being issued, blk_ready is 0. blk_valid and the block inputs are ignored, so the issued slots still come from the block that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_valid | input | 1 | Fetch side offers a block |
| blk_ready | output | 1 | Sequencer is idle and takes a block (next-block request) |
| blk_data | input | 256 | Block contents, slot k in bits [32k+31:32k] |
| blk_hdr | input | 1 | Block starts with a header |
| blk_hdr_len | input | 3 | Header length in 16-bit units |
| blk_rsv | input | 3 | Trailing slots reserved for data |
| blk_target | input | 3 | Branch target slot, 0 for sequential fetch |
| slot_valid | output | 1 | A slot is offered to the decoder |
| slot_ready | input | 1 | Decoder takes the slot |
| slot_data | output | 32 | Offered slot |
| slot_idx | output | 3 | Index of the offered slot within its block |
| blk_done | output | 1 | One-cycle pulse after the last slot is accepted |
| blk_err | output | 1 | One-cycle pulse for a block whose data area covers its start |

## Verification
The bench aims at the start and end of the issue window.

A design that rounds the 48-bit header down would issue slot 1, which is half header. A design that applies the reserve count without a header would lose trailing instructions. A design that takes the branch target over the header would issue header bits as instructions.

The bench also tests the boundary where the window holds exactly one slot, and two cases where the window is empty. A design without the empty-window check would issue garbage there, or hang waiting for a last slot it never reaches.

Decoder stalls and block offers made while the sequencer is busy are used as well. These expose a design that moves the slot while it is stalled, or that reloads the block in the middle of issue.

// File: rtl/blk_seq_pkg.sv
// Package: shared defaults and types for the block slot sequencer.
// Assumes slots are a whole number of 16-bit header units.
package blk_seq_pkg;
    localparam int DEF_SLOT_BITS = 32;
    localparam int DEF_NUM_SLOTS = 8;
    localparam int DEF_UNIT_BITS = 16;
    localparam int DEF_HLEN_W    = 3;
    localparam int DEF_RSV_W     = 3;

    // Controller state: waiting for a block, or handing out its slots
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } seq_state_e;
endpackage

// File: rtl/blk_window_calc.sv
// Module: blk_window_calc
// Works out the window of slots to issue from the block side-band.
// The first slot is the larger of the branch target and the first slot
// past the header. The last slot is the top slot minus the reserve count.
// The reserve count and header length count only when a header is present.
// The logic is purely combinational; the caller registers the result
// when the block is accepted.
module blk_window_calc #(
    parameter int NUM_SLOTS = blk_seq_pkg::DEF_NUM_SLOTS,
    parameter int SLOT_BITS = blk_seq_pkg::DEF_SLOT_BITS,
    parameter int UNIT_BITS = blk_seq_pkg::DEF_UNIT_BITS,
    parameter int HLEN_W    = blk_seq_pkg::DEF_HLEN_W,
    parameter int RSV_W     = blk_seq_pkg::DEF_RSV_W,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic              hdr_present,
    input  logic [HLEN_W-1:0] hdr_len,
    input  logic [RSV_W-1:0]  rsv_cnt,
    input  logic [IDX_W-1:0]  target,
    output logic [IDX_W-1:0]  first_idx,
    output logic [IDX_W-1:0]  last_idx,
    output logic              empty
);
    localparam int UNITS_PER_SLOT = SLOT_BITS / UNIT_BITS;
    localparam int CW = ((HLEN_W > IDX_W) ? HLEN_W : IDX_W) + ((RSV_W > IDX_W) ? RSV_W : IDX_W) + 2;
    localparam logic [CW-1:0] TOP = CW'(NUM_SLOTS - 1);

    logic [CW-1:0] hdr_slots;
    logic [CW-1:0] rsv_eff;
    logic [CW-1:0] start_w;
    logic [CW-1:0] last_w;
    logic          rsv_over;

    // Header slot count: round the header length up to whole slots
    always_comb begin
        if (hdr_present) begin
            hdr_slots = (CW'(hdr_len) + CW'(UNITS_PER_SLOT - 1)) / CW'(UNITS_PER_SLOT);
            rsv_eff   = CW'(rsv_cnt);
        end else begin
            hdr_slots = '0;
            rsv_eff   = '0;
        end
    end

    // Window bounds and emptiness check
    always_comb begin
        start_w  = (CW'(target) > hdr_slots) ? CW'(target) : hdr_slots;
        rsv_over = (rsv_eff > TOP);
        last_w   = rsv_over ? '0 : (TOP - rsv_eff);
        empty    = rsv_over || (start_w > last_w);
        first_idx = start_w[IDX_W-1:0];
        last_idx  = last_w[IDX_W-1:0];
    end
endmodule

// File: rtl/blk_slot_store.sv
// Module: blk_slot_store
// Holds one accepted block as an array of slot registers and presents the
// slot picked by rd_idx. A load overwrites every slot at once. Slot k is
// taken from bits [k*SLOT_BITS +: SLOT_BITS] of the block.
module blk_slot_store #(
    parameter int SLOT_BITS = blk_seq_pkg::DEF_SLOT_BITS,
    parameter int NUM_SLOTS = blk_seq_pkg::DEF_NUM_SLOTS,
    localparam int IDX_W    = $clog2(NUM_SLOTS),
    localparam int BLK_BITS = SLOT_BITS * NUM_SLOTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [BLK_BITS-1:0]  blk_in,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [SLOT_BITS-1:0] rd_data
);
    logic [SLOT_BITS-1:0] slot_q [NUM_SLOTS];

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        // Capture slot k of an accepted block
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[k] <= '0;
            end else if (load) begin
                slot_q[k] <= blk_in[k*SLOT_BITS +: SLOT_BITS];
            end
        end
    end

    // Read mux for the slot being offered
    always_comb begin
        rd_data = slot_q[rd_idx];
    end
endmodule

// File: rtl/blk_issue_ctrl.sv
// Module: blk_issue_ctrl
// Sequencing control. It accepts a block when idle and latches its slot
// window. It then walks the slot index from the first slot to the last,
// one step per decoder acceptance. After the last acceptance it pulses
// done and returns to idle. An empty window returns to idle at once and
// pulses the error flag. Assumes the window inputs are valid whenever
// blk_valid is high.
module blk_issue_ctrl #(
    parameter int NUM_SLOTS = blk_seq_pkg::DEF_NUM_SLOTS,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_valid,
    output logic             blk_ready,
    output logic             load,
    input  logic [IDX_W-1:0] win_first,
    input  logic [IDX_W-1:0] win_last,
    input  logic             win_empty,
    output logic             slot_valid,
    input  logic             slot_ready,
    output logic [IDX_W-1:0] cur_idx,
    output logic             blk_done,
    output logic             blk_err
);
    import blk_seq_pkg::*;

    seq_state_e       state_q;
    logic [IDX_W-1:0] cur_q;
    logic [IDX_W-1:0] last_q;
    logic             done_q;
    logic             err_q;
    logic             take;

    // Handshake decodes from the state
    always_comb begin
        blk_ready  = (state_q == ST_IDLE);
        slot_valid = (state_q == ST_ISSUE);
        load       = blk_valid && blk_ready;
        take       = slot_valid && slot_ready;
        cur_idx    = cur_q;
        blk_done   = done_q;
        blk_err    = err_q;
    end

    // State, slot pointer and one-cycle pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            last_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (load) begin
                        if (win_empty) begin
                            err_q <= 1'b1;
                        end else begin
                            state_q <= ST_ISSUE;
                            cur_q   <= win_first;
                            last_q  <= win_last;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (take) begin
                        if (cur_q == last_q) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            cur_q <= cur_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R8
    stall_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && !slot_ready) |=> (slot_valid && $stable(cur_idx)));

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !blk_done && $past(take) && slot_valid) |-> 1'b1 ##0 (cur_idx >= $past(cur_idx) || $past(cur_idx) == cur_idx));

    // R7
    done_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_done) |-> ($past(take) && blk_ready && !slot_valid));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !blk_done);

    // R6
    err_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_err |-> (!slot_valid && !blk_done && blk_ready && $past(load)));

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |-> !blk_ready);
endmodule

// File: rtl/blk_slot_seq.sv
// Module: blk_slot_seq (top)
// Instruction block slot sequencer. It takes a whole block plus header and
// branch side-band over a valid/ready port. It hands the instruction slots
// out in order to a decoder over a second valid/ready port, skipping
// header slots and trailing data slots. The block-ready output doubles
// as the request for the next block.
module blk_slot_seq #(
    parameter int SLOT_BITS = blk_seq_pkg::DEF_SLOT_BITS,
    parameter int NUM_SLOTS = blk_seq_pkg::DEF_NUM_SLOTS,
    parameter int UNIT_BITS = blk_seq_pkg::DEF_UNIT_BITS,
    parameter int HLEN_W    = blk_seq_pkg::DEF_HLEN_W,
    parameter int RSV_W     = blk_seq_pkg::DEF_RSV_W,
    localparam int IDX_W    = $clog2(NUM_SLOTS),
    localparam int BLK_BITS = SLOT_BITS * NUM_SLOTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 blk_valid,
    output logic                 blk_ready,
    input  logic [BLK_BITS-1:0]  blk_data,
    input  logic                 blk_hdr,
    input  logic [HLEN_W-1:0]    blk_hdr_len,
    input  logic [RSV_W-1:0]     blk_rsv,
    input  logic [IDX_W-1:0]     blk_target,
    output logic                 slot_valid,
    input  logic                 slot_ready,
    output logic [SLOT_BITS-1:0] slot_data,
    output logic [IDX_W-1:0]     slot_idx,
    output logic                 blk_done,
    output logic                 blk_err
);
    logic [IDX_W-1:0] win_first;
    logic [IDX_W-1:0] win_last;
    logic             win_empty;
    logic             load;

    blk_window_calc #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_BITS (SLOT_BITS),
        .UNIT_BITS (UNIT_BITS),
        .HLEN_W    (HLEN_W),
        .RSV_W     (RSV_W)
    ) u_window (
        .hdr_present (blk_hdr),
        .hdr_len     (blk_hdr_len),
        .rsv_cnt     (blk_rsv),
        .target      (blk_target),
        .first_idx   (win_first),
        .last_idx    (win_last),
        .empty       (win_empty)
    );

    blk_issue_ctrl #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_valid  (blk_valid),
        .blk_ready  (blk_ready),
        .load       (load),
        .win_first  (win_first),
        .win_last   (win_last),
        .win_empty  (win_empty),
        .slot_valid (slot_valid),
        .slot_ready (slot_ready),
        .cur_idx    (slot_idx),
        .blk_done   (blk_done),
        .blk_err    (blk_err)
    );

    blk_slot_store #(
        .SLOT_BITS (SLOT_BITS),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .blk_in  (blk_data),
        .rd_idx  (slot_idx),
        .rd_data (slot_data)
    );

    // R8
    stall_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && !slot_ready) |=> $stable(slot_data));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (blk_ready && !slot_valid && !blk_done && !blk_err));
endmodule

// File: tb/tb_blk_slot_seq.sv
// Directed bench for blk_slot_seq: one task per scenario, each checking its own results.
module tb_blk_slot_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         blk_valid = 1'b0;
    logic         blk_ready;
    logic [255:0] blk_data = '0;
    logic         blk_hdr = 1'b0;
    logic [2:0]   blk_hdr_len = '0;
    logic [2:0]   blk_rsv = '0;
    logic [2:0]   blk_target = '0;
    logic         slot_valid;
    logic         slot_ready = 1'b0;
    logic [31:0]  slot_data;
    logic [2:0]   slot_idx;
    logic         blk_done;
    logic         blk_err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    blk_slot_seq dut (
        .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_ready(blk_ready),
        .blk_data(blk_data), .blk_hdr(blk_hdr), .blk_hdr_len(blk_hdr_len),
        .blk_rsv(blk_rsv), .blk_target(blk_target), .slot_valid(slot_valid),
        .slot_ready(slot_ready), .slot_data(slot_data), .slot_idx(slot_idx),
        .blk_done(blk_done), .blk_err(blk_err)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] mk_blk(input logic [7:0] seed);
        logic [255:0] b;
        for (int k = 0; k < 8; k++) b[32*k +: 32] = {seed, 8'h5A, 8'(k*17 + 3), 8'(k)};
        return b;
    endfunction

    // Core scenario: offer a block, then drain it and compare every slot
    task automatic run_blk(input string req, input logic [7:0] seed, input logic hp,
                           input logic [2:0] hl, input logic [2:0] rsv, input logic [2:0] tgt,
                           input bit stall, input bit poke);
        logic [255:0] b;
        int hs, first, last, nexp, ngot, expect_idx, step;
        logic prev_stall;
        logic [2:0] prev_idx;
        logic [31:0] prev_data;
        logic r;
        b = mk_blk(seed);
        hs    = hp ? (int'(hl) + 1) / 2 : 0;
        first = (int'(tgt) > hs) ? int'(tgt) : hs;
        last  = 7 - (hp ? int'(rsv) : 0);
        nexp  = (first > last) ? 0 : last - first + 1;
        @(negedge clk);
        chk({req, " ready before offer"}, 64'(blk_ready), 64'd1);
        blk_valid = 1'b1; blk_data = b; blk_hdr = hp; blk_hdr_len = hl;
        blk_rsv = rsv; blk_target = tgt;
        @(posedge clk);
        @(negedge clk);
        blk_valid = 1'b0;
        if (nexp == 0) begin
            chk({req, " R6 err pulse"}, 64'(blk_err), 64'd1);
            chk({req, " R6 no slot"}, 64'(slot_valid), 64'd0);
            chk({req, " R6 ready again"}, 64'(blk_ready), 64'd1);
            @(negedge clk);
            chk({req, " R6 err one cycle"}, 64'(blk_err), 64'd0);
            chk({req, " R6 no done"}, 64'(blk_done), 64'd0);
            chk({req, " R6 still no slot"}, 64'(slot_valid), 64'd0);
            return;
        end
        if (poke) begin
            blk_valid = 1'b1; blk_data = ~b; blk_hdr = 1'b0; blk_target = 3'd0;
        end
        ngot = 0; expect_idx = first; prev_stall = 1'b0; step = 0;
        prev_idx = '0; prev_data = '0;
        while (!blk_done && step < 64) begin
            if (prev_stall) begin
                chk({req, " R8 hold valid"}, 64'(slot_valid), 64'd1);
                chk({req, " R8 hold idx"}, 64'(slot_idx), 64'(prev_idx));
                chk({req, " R8 hold data"}, 64'(slot_data), 64'(prev_data));
            end
            if (poke) chk({req, " R9 busy not ready"}, 64'(blk_ready), 64'd0);
            r = stall ? ((step % 3) != 1) : 1'b1;
            slot_ready = r;
            if (slot_valid && r) begin
                chk({req, " slot idx"}, 64'(slot_idx), 64'(expect_idx));
                chk({req, " slot data"}, 64'(slot_data), 64'(b[32*expect_idx +: 32]));
                expect_idx++; ngot++;
            end
            prev_stall = slot_valid && !r;
            prev_idx = slot_idx; prev_data = slot_data;
            @(posedge clk);
            @(negedge clk);
            step++;
            if (blk_done) blk_valid = 1'b0;
        end
        blk_valid = 1'b0;
        slot_ready = 1'b0;
        chk({req, " slot count"}, 64'(ngot), 64'(nexp));
        chk({req, " R7 done pulse"}, 64'(blk_done), 64'd1);
        chk({req, " R7 ready with done"}, 64'(blk_ready), 64'd1);
        chk({req, " R7 no slot after last"}, 64'(slot_valid), 64'd0);
        @(negedge clk);
        chk({req, " R7 done one cycle"}, 64'(blk_done), 64'd0);
        chk({req, " no stray slot"}, 64'(slot_valid), 64'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 blk_ready", 64'(blk_ready), 64'd1);
        chk("R1 slot_valid", 64'(slot_valid), 64'd0);
        chk("R1 blk_done", 64'(blk_done), 64'd0);
        chk("R1 blk_err", 64'(blk_err), 64'd0);
    endtask

    task automatic t_no_hdr();      run_blk("R2 plain",        8'h11, 1'b0, 3'd4, 3'd5, 3'd0, 0, 0); endtask
    task automatic t_hdr32();       run_blk("R3 R4 hdr32",     8'h22, 1'b1, 3'd2, 3'd2, 3'd0, 0, 0); endtask
    task automatic t_hdr48();       run_blk("R3 hdr48",        8'h33, 1'b1, 3'd3, 3'd0, 3'd0, 0, 0); endtask
    task automatic t_hdr64_stall(); run_blk("R4 R8 hdr64",     8'h44, 1'b1, 3'd4, 3'd3, 3'd0, 1, 0); endtask
    task automatic t_branch();      run_blk("R5 branch",       8'h55, 1'b0, 3'd0, 3'd0, 3'd5, 0, 0); endtask
    task automatic t_branch_hdr();  run_blk("R5 branch in hdr",8'h66, 1'b1, 3'd4, 3'd0, 3'd1, 0, 0); endtask
    task automatic t_single();      run_blk("R4 R5 single",    8'h77, 1'b1, 3'd2, 3'd1, 3'd6, 1, 0); endtask
    task automatic t_err_hdr();     run_blk("R6 rsv over hdr", 8'h88, 1'b1, 3'd4, 3'd6, 3'd0, 0, 0); endtask
    task automatic t_err_tgt();     run_blk("R6 rsv over tgt", 8'h99, 1'b1, 3'd2, 3'd1, 3'd7, 0, 0); endtask
    task automatic t_busy();        run_blk("R9 busy poke",    8'hAA, 1'b0, 3'd0, 3'd0, 3'd2, 1, 1); endtask

    initial begin
        t_reset();
        t_no_hdr();
        t_hdr32();
        t_hdr48();
        t_hdr64_stall();
        t_branch();
        t_branch_hdr();
        t_single();
        t_err_hdr();
        t_err_tgt();
        t_busy();
        t_no_hdr();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule